// File: doc/BRIEF.md
# PHY Management Frame Master

This block is the master side of the two-wire PHY management interface. One command runs one register access: the host places the access type, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data on its inputs, then pulses start. The block produces the management clock by dividing the system clock. It shifts the whole frame out on the data line, most significant bit first, and returns the line to the PHY at the point the access type calls for.

The two access types hand the line over at different points. On a read the master stops driving at the first turnaround bit. The PHY then drives a zero, followed by 16 data bits that the master samples on rising management-clock edges and returns with a one-cycle done pulse. On a write the master drives the turnaround bits itself and keeps the line through the last data bit. It releases the line only in a single idle bit period that follows. Reads get the same idle bit period, so both access types take the same number of cycles.

Top module: `phy_mgmt_master`

## Requirements
- R1: After reset, and whenever busy is low, the management clock is low and the data output enable is low.
- R2: While a frame is in progress the management clock has a period of DIV system clocks (DIV even, at least 2): low for the first DIV/2 cycles and high for the rest. The data output and its enable change only when the management clock falls.
- R3: A frame begins with 32 driven bits of value 1, then the start field: a 0 followed by a 1.
- R4: The next two bits are the opcode. A read sends 1 then 0; a write sends 0 then 1.
- R5: After the opcode come the PHY address (5 bits) and then the register address (5 bits), each most significant bit first.
- R6: On a write the master drives the two turnaround bits as 1 then 0, then the 16 write-data bits most significant bit first. The enable stays high for all 64 frame bits.
- R7: On a read the enable goes low at bit 46 (the first turnaround bit, counting bit 0 as the first preamble bit) and stays low. Bits 48 to 63 are sampled from the line on rising management-clock edges, most significant bit first, and appear on rdata_o.
- R8: After bit 63 there is one idle bit period with the enable low. Then done pulses for exactly one cycle, and busy falls in that same cycle. This happens exactly 65*DIV system clocks after the edge that accepts start.
- R9: A start pulse that arrives while busy is high is ignored. The frame in progress and its timing do not change.
- R10: Busy is high in the cycle after an accepted start and stays high until done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle request to run one access |
| is_read_i | input | 1 | 1 selects a read, 0 a write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse at the end of an access |
| rdata_o | output | 16 | Data captured by the last read |
| mgmt_clk_o | output | 1 | Management clock |
| mgmt_do_o | output | 1 | Data line output value |
| mgmt_oe_o | output | 1 | Data line output enable |
| mgmt_di_i | input | 1 | Data line input value |

## Verification
Busy is due one system clock after the edge that accepts start. Done and the captured read data are due exactly 65*DIV system clocks after that edge. The bench counts system-clock edges from the accepting edge and requires done at exactly that count, checking the outputs at falling system-clock edges. Frame bits and their enables are recorded by a PHY model at each rising management-clock edge, where the data output is settled half a period after it changed. The model measures the spacing of those edges in system clocks, so each bit is checked in the bit period it belongs to.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_FIRST   = FRAME_BITS - DATA_W - 2;
  localparam int DATA_FIRST = FRAME_BITS - DATA_W;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_REST  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF   = CW'(DIV / 2);
  localparam logic [CW-1:0] PRE_HI = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mclk_q, mclk_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (!run_i || wrap) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
    mclk_d = run_i && (cnt_d >= HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mclk_q <= mclk_d;
    end
  end

  assign mclk_o = mclk_q;
  assign rise_o = run_i && (cnt_q == PRE_HI);
  assign fall_o = run_i && wrap;
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_read_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mgmt_di_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mgmt_do_o,
  output logic              mgmt_oe_o
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA_BIT   = BW'(TA_FIRST);
  localparam logic [BW-1:0] DAT_BIT  = BW'(DATA_FIRST);

  seq_state_t            state_q, state_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic                  rd_q, rd_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;
  logic                  done_q, done_d;
  logic                  oe_q, oe_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sr_d    = sr_q;
    rd_d    = rd_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FRAME;
          bit_d   = '0;
          rd_d    = is_read_i;
          sr_d    = {{PRE_BITS{1'b1}}, SOF_BITS,
                     is_read_i ? OP_RD : OP_WR,
                     phy_addr_i, reg_addr_i,
                     is_read_i ? 2'b00 : TA_WR,
                     is_read_i ? {DATA_W{1'b0}} : wdata_i};
        end
      end
      ST_FRAME: begin
        if (rise_i && rd_q && (bit_q >= DAT_BIT))
          rdata_d = {rdata_q[DATA_W-2:0], mgmt_di_i};
        if (fall_i) begin
          if (bit_q == LAST_BIT) begin
            state_d = ST_REST;
          end else begin
            bit_d = bit_q + 1'b1;
            sr_d  = {sr_q[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
      ST_REST: begin
        if (fall_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    // read hands the line to the PHY from the first turnaround bit on
    oe_d = (state_d == ST_FRAME) && !(rd_d && (bit_d >= TA_BIT));
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sr_q    <= '0;
      rd_q    <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sr_q    <= sr_d;
      rd_q    <= rd_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      oe_q    <= oe_d;
    end
  end

  assign run_o     = (state_q != ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign mgmt_do_o = sr_q[FRAME_BITS-1];
  assign mgmt_oe_o = oe_q;
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        is_read_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mgmt_clk_o,
  output logic        mgmt_do_o,
  output logic        mgmt_oe_o,
  input  logic        mgmt_di_i
);
  logic rst_meta_q, rst_sync_n;
  logic run, rise, fall;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mgmt_clk_div #(.DIV(DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (run),
    .mclk_o (mgmt_clk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mgmt_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .is_read_i  (is_read_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .mgmt_di_i  (mgmt_di_i),
    .run_o      (run),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .mgmt_do_o  (mgmt_do_o),
    .mgmt_oe_o  (mgmt_oe_o)
  );
endmodule

// File: rtl/phy_mgmt_master_chk.sv
module phy_mgmt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic mgmt_clk_o,
  input logic mgmt_do_o,
  input logic mgmt_oe_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mgmt_oe_o && !mgmt_clk_o));

  p_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_clk_o && $past(mgmt_clk_o)) |-> ($stable(mgmt_do_o) && $stable(mgmt_oe_o)));

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_start_kept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && mgmt_clk_o) |=> busy_o);
endmodule

bind phy_mgmt_master phy_mgmt_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mgmt_clk_o (mgmt_clk_o),
  .mgmt_do_o  (mgmt_do_o),
  .mgmt_oe_o  (mgmt_oe_o)
);

// File: tb/sim_phy_mgmt_master.sv
module sim_phy_mgmt_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam logic [4:0] MY_PHY = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_read = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic        busy, done, mclk, mdo, moe, mdi;
  logic [15:0] rdata;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int txn_id = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;

  phy_mgmt_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .is_read_i(is_read),
    .phy_addr_i(phy_addr), .reg_addr_i(reg_addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mgmt_clk_o(mclk), .mgmt_do_o(mdo), .mgmt_oe_o(moe), .mgmt_di_i(mdi)
  );

  // ---------------- PHY model ----------------
  logic [15:0] phy_mem [32];
  logic [63:0] rec_do, rec_oe;
  int          bit_n = 0;
  int          seen_id = -1;
  int          last_rise = 0;
  bit          per_err = 0, rest_err = 0, phy_rd = 0;
  logic [15:0] rd_val = '0;
  logic        drv = 1'b0, drv_val = 1'b1;

  assign mdi = moe ? mdo : (drv ? drv_val : 1'b1);

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 16'h0313) ^ 16'h5A5A;
  endfunction

  initial for (int i = 0; i < 32; i++) phy_mem[i] = init_val(i);

  always @(posedge mclk) begin
    if (seen_id != txn_id) begin
      seen_id = txn_id; bit_n = 0; per_err = 0; rest_err = 0; phy_rd = 0;
      rec_do = '0; rec_oe = '0;
    end
    if (bit_n > 0 && (cyc - last_rise) != DIV) per_err = 1;
    last_rise = cyc;
    if (bit_n < 64) begin
      rec_do[63-bit_n] = mdo;
      rec_oe[63-bit_n] = moe;
      if (bit_n == 45) begin
        phy_rd = (rec_do[29:28] == 2'b10) && (rec_do[27:23] == MY_PHY);
        rd_val = phy_mem[rec_do[22:18]];
      end
      if (bit_n == 63 && rec_do[29:28] == 2'b01 && rec_do[27:23] == MY_PHY
          && rec_do[17:16] == 2'b10)
        phy_mem[rec_do[22:18]] = rec_do[15:0];
    end else if (moe) begin
      rest_err = 1;
    end
    bit_n++;
  end

  always @(negedge mclk) begin
    if (phy_rd && bit_n >= 47 && bit_n <= 63) begin
      drv = 1'b1;
      drv_val = (bit_n == 47) ? 1'b0 : rd_val[63-bit_n];
    end else begin
      drv = 1'b0;
    end
  end

  // ---------------- bench model ----------------
  logic [15:0] shadow [32];
  initial for (int i = 0; i < 32; i++) shadow[i] = init_val(i);

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] pa, logic [4:0] ra,
                                            logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
            rd ? 2'b00 : 2'b10, rd ? 16'h0000 : wd};
  endfunction

  function automatic logic [63:0] exp_oe(bit rd);
    return rd ? (~64'h0 << 18) : ~64'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd,
                         bit inject);
    int n;
    logic [63:0] ef, eo;
    logic [15:0] er;
    ef = exp_frame(rd, pa, ra, wd);
    eo = exp_oe(rd);
    er = (pa == MY_PHY) ? shadow[ra] : 16'hFFFF;
    @(negedge clk);
    txn_id++;
    is_read = rd; phy_addr = pa; reg_addr = ra; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", 64'(busy), 64'd1);
    n = 0;
    while (!done && n < 80 * DIV) begin
      @(negedge clk);
      n++;
      if (inject && n == 37 * DIV) begin
        is_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd; start = 1'b1;
        @(negedge clk);
        n++;
        start = 1'b0;
      end
    end
    chk(n == 65 * DIV, inject ? "R9 timing with ignored start" : "R8 done timing",
        64'(n), 64'(65 * DIV));
    chk(done === 1'b1 && busy === 1'b0, "R8 busy falls with done",
        {62'd0, done, busy}, 64'd2);
    chk(rec_do[63:30] == ef[63:30], "R3 preamble and start field",
        64'(rec_do[63:30]), 64'(ef[63:30]));
    chk(rec_do[29:28] == ef[29:28], "R4 opcode", 64'(rec_do[29:28]), 64'(ef[29:28]));
    chk(rec_do[27:18] == ef[27:18], "R5 addresses", 64'(rec_do[27:18]), 64'(ef[27:18]));
    chk(!per_err, "R2 clock period", 64'(per_err), 64'd0);
    chk(!rest_err, "R8 idle bit released", 64'(rest_err), 64'd0);
    if (rd) begin
      chk(rec_oe == eo, "R7 read release", rec_oe, eo);
      chk(rdata == er, "R7 read data", 64'(rdata), 64'(er));
    end else begin
      chk(rec_oe == eo, "R6 write enable", rec_oe, eo);
      chk(rec_do[17:0] == ef[17:0], "R6 turnaround and data",
          64'(rec_do[17:0]), 64'(ef[17:0]));
      if (pa == MY_PHY) shadow[ra] = wd;
    end
    if (inject)
      chk((rec_do & eo) == (ef & eo), "R9 frame unchanged", rec_do & eo, ef & eo);
    @(negedge clk);
    chk(!moe && !mclk && !busy, "R1 quiet between frames",
        {61'd0, moe, mclk, busy}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !moe && !mclk && !done, "R1 reset state",
        {60'd0, busy, moe, mclk, done}, 64'd0);
    run_txn(1'b1, MY_PHY, 5'd7, 16'h0, 1'b0);
    run_txn(1'b0, MY_PHY, 5'd0, 16'h0000, 1'b0);
    run_txn(1'b0, MY_PHY, 5'd31, 16'hFFFF, 1'b0);
    run_txn(1'b1, MY_PHY, 5'd0, 16'h0, 1'b0);
    run_txn(1'b1, MY_PHY, 5'd31, 16'h0, 1'b0);
    run_txn(1'b1, 5'd17, 5'd4, 16'h0, 1'b0);
    run_txn(1'b0, MY_PHY, 5'd9, 16'hA5C3, 1'b1);
    run_txn(1'b1, MY_PHY, 5'd9, 16'h0, 1'b1);
    for (int k = 0; k < 24; k++) begin
      bit          rd;
      logic [4:0]  pa, ra;
      logic [15:0] wd;
      rd = 1'($urandom % 2);
      pa = ($urandom % 4 == 0) ? 5'($urandom) : MY_PHY;
      ra = 5'($urandom);
      wd = 16'($urandom);
      run_txn(rd, pa, ra, wd, 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule